// File: doc/BRIEF.md
# Edge-Captured Maskable Interrupt Latch

This block turns a transition on one asynchronous input line into a held interrupt request for a processor. The line passes through a two-stage synchronizer. An edge detector then watches the line for the direction chosen by a static polarity input. A qualifying edge sets a pending flag. The flag stays set, whatever the line does next, until the processor clears it with a command.

The processor controls the block through the ordinary addressed data-output write path. A write to one address loads an enable mask from data bit 15. A write to a second address clears the pending flag. The processor drives an active-low request line only while the flag is pending and the mask is enabled. A masked event is still recorded, and the processor can poll for it. The pending flag appears as bit 15 of the module's input data word. The other fifteen input lines fill the lower bits of that word unchanged.

The interface has no streaming data path. The register write port takes a one-cycle strobe that is accepted in every cycle, so there is no back-pressure. Read data is combinational.

Top module: `edge_irq_latch`

## Requirements
- R1: While reset is asserted, and after it is released, the pending flag and the mask are both 0 and `irq_n` is 1.
- R2: A qualifying edge on `irq_in` sets the pending flag. With `pol`=1 this is a 0-to-1 change, and with `pol`=0 it is a 1-to-0 change. The flag appears on `rd_data[15]` after the third rising clock edge that follows the input change.
- R3: A change of `irq_in` in the direction opposite to `pol` does not set the pending flag.
- R4: Once set, the pending flag stays set through any later activity on `irq_in` until a clear command arrives.
- R5: A write with `wr_addr` equal to `CLR_ADDR` (default 1) clears the pending flag at that clock edge, whatever `wr_data` holds, and leaves the mask unchanged.
- R6: A write with `wr_addr` equal to `MASK_ADDR` (default 0) loads the mask from `wr_data[15]`, where 1 enables the request.
- R7: `irq_n` is registered. It is 0 in the cycle after the pending flag and the mask are both 1, and it returns to 1 in the cycle after either of them is cleared.
- R8: While the mask is 0, a pending event is still recorded and readable on `rd_data[15]`, and `irq_n` stays 1.
- R9: If a qualifying edge and a clear command occur in the same cycle, the pending flag ends up set.
- R10: `rd_data` is {pending flag, `in_word`}. A write to any address other than the mask and clear addresses has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Asynchronous interrupt line |
| pol | input | 1 | Static edge select: 1 for rising, 0 for falling |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bit 15 is the mask value |
| in_word | input | DATA_W-1 | Other input lines of the data word |
| rd_data | output | DATA_W | Input data word, with the pending flag in bit 15 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The input line is driven with rising and with falling steps under each polarity setting. Each run confirms that only the selected direction sets the flag, and that the opposite edge leaves it clear. Activity on the line while the flag is already held shows whether the flag is sticky. Clears, and mask loads of both values, are issued while the flag is pending. These separate the recorded state from the driven request and expose the one-cycle lag of the request. A clear that lands in the same cycle as a new edge shows that the set takes priority. A write to an unused address shows that decoding is exact.

// File: rtl/eil_pkg.sv
package eil_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_MASK = 2'd1,
    CMD_CLR  = 2'd2
  } eil_cmd_e;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic sync_valid
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      fill_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      fill_q  <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  assign sync_out   = chain_q[STAGES-1];
  assign sync_valid = fill_q[STAGES-1];
endmodule

// File: rtl/eil_edge.sv
module eil_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic level_valid,
  input  logic pol,
  output logic hit
);
  logic prev_q;
  logic primed_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= level;
      primed_q <= level_valid;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign hit  = primed_q & (pol ? rise : fall);
endmodule

// File: rtl/eil_ctrl.sv
module eil_ctrl
  import eil_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int MASK_ADDR = 0,
  parameter int CLR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_pulse,
  output logic              pending,
  output logic              mask,
  output logic              clr_pulse,
  output logic              req_n
);
  localparam int MASK_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_ADDR);

  eil_cmd_e cmd;
  logic pending_q, mask_q, req_n_q;

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (wr_addr == MASK_A)     cmd = CMD_MASK;
      else if (wr_addr == CLR_A) cmd = CMD_CLR;
    end
  end

  assign clr_pulse = (cmd == CMD_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      mask_q    <= 1'b0;
      req_n_q   <= 1'b1;
    end else begin
      if (set_pulse)      pending_q <= 1'b1;
      else if (clr_pulse) pending_q <= 1'b0;
      if (cmd == CMD_MASK) mask_q <= wr_data[MASK_BIT];
      req_n_q <= ~(pending_q & mask_q);
    end
  end

  assign pending = pending_q;
  assign mask    = mask_q;
  assign req_n   = req_n_q;
endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MASK_ADDR   = 0,
  parameter int CLR_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              pol,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-2:0] in_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  logic sync_lvl, sync_ok, edge_hit;
  logic pending_q, mask_q, clr_pulse;

  eil_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in),
    .sync_out(sync_lvl), .sync_valid(sync_ok)
  );

  eil_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_lvl), .level_valid(sync_ok),
    .pol(pol), .hit(edge_hit)
  );

  eil_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_ADDR(MASK_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .set_pulse(edge_hit), .pending(pending_q),
    .mask(mask_q), .clr_pulse(clr_pulse), .req_n(irq_n)
  );

  assign rd_data = {pending_q, in_word};
endmodule

// File: rtl/eil_checker.sv
module eil_checker #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int MASK_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pol,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              sync_lvl,
  input logic              edge_hit,
  input logic              clr_pulse,
  input logic              pending_q,
  input logic              mask_q,
  input logic              irq_n
);
  AST_REQ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && mask_q) |=> !irq_n); // R7
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending_q && mask_q) |=> irq_n); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pending_q); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !clr_pulse) |=> pending_q); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !edge_hit) |=> !pending_q); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(MASK_ADDR)) |=> (mask_q == $past(wr_data[DATA_W-1]))); // R6
  AST_EDGE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (sync_lvl == pol)); // R3
endmodule

bind edge_irq_latch eil_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR)
) u_eil_checker (
  .clk(clk), .rst_n(rst_n), .pol(pol), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sync_lvl(sync_lvl), .edge_hit(edge_hit),
  .clr_pulse(clr_pulse), .pending_q(pending_q), .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/edge_irq_latch_tb_top.sv
module edge_irq_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_in = 1'b0;
  logic pol = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [14:0] in_word = 15'h2A5C;
  logic [15:0] rd_data;
  logic irq_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit    chk;
    logic  e_irqn;
    logic  e_pend;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  edge_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .in_word(in_word),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // monitor: compares each expectation right after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        if (it.chk) begin
          n_checks++;
          if (irq_n !== it.e_irqn || rd_data[15] !== it.e_pend ||
              rd_data[14:0] !== in_word) begin
            n_fail++;
            $display("FAIL %s: irq_n=%b pend=%b low=%h expected irq_n=%b pend=%b low=%h",
                     it.tag, irq_n, rd_data[15], rd_data[14:0],
                     it.e_irqn, it.e_pend, in_word);
          end
        end
      end
    end
  end

  task automatic step(input logic irq, input logic we, input logic [3:0] a,
                      input logic [15:0] d, input bit chk, input logic e_irqn,
                      input logic e_pend, input string tag);
    exp_t it;
    @(negedge clk);
    irq_in = irq; wr_en = we; wr_addr = a; wr_data = d;
    it.chk = chk; it.e_irqn = e_irqn; it.e_pend = e_pend; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle(input int n, input logic e_irqn, input logic e_pend,
                      input string tag);
    for (int i = 0; i < n; i++) step(irq_in, 1'b0, 4'd0, 16'h0, 1'b1, e_irqn, e_pend, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_checks++;
    if (irq_n !== 1'b1 || rd_data[15] !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: irq_n=%b pend=%b expected 1 0", irq_n, rd_data[15]);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(3, 1'b1, 1'b0, "R1 after reset");
    // R6 enable mask; nothing pending yet
    step(1'b0, 1'b1, 4'd0, 16'h8000, 1'b1, 1'b1, 1'b0, "R6 mask on, idle");
    // R2 rising edge, pol=1
    step(1'b1, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R2 sync stage 1");
    idle(1, 1'b1, 1'b0, "R2 sync stage 2");
    idle(1, 1'b1, 1'b1, "R2 pending after rise");
    idle(1, 1'b0, 1'b1, "R7 request driven");
    // R4 fall of line does not drop flag
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0, 1'b1, "R4 held");
    // R5 clear, R7 release one cycle later
    step(1'b0, 1'b1, 4'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 cleared");
    idle(1, 1'b1, 1'b0, "R7 release after clear");
    // new event
    step(1'b1, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R2 second rise s1");
    idle(1, 1'b1, 1'b0, "R2 second rise s2");
    idle(1, 1'b1, 1'b1, "R2 second rise set");
    idle(1, 1'b0, 1'b1, "R7 second request");
    // R8 mask off keeps record
    step(1'b1, 1'b1, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b1, "R7 mask write lag");
    idle(2, 1'b1, 1'b1, "R8 masked but recorded");
    step(1'b1, 1'b1, 4'd0, 16'h8000, 1'b1, 1'b1, 1'b1, "R6 mask on lag");
    idle(1, 1'b0, 1'b1, "R6 request after unmask");
    // R9 edge and clear collide
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0, 1'b1, "R4 held on fall");
    step(1'b1, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0, 1'b1, "R9 rise s1");
    idle(1, 1'b0, 1'b1, "R9 rise s2");
    step(1'b1, 1'b1, 4'd1, 16'h0, 1'b1, 1'b0, 1'b1, "R9 set beats clear");
    idle(1, 1'b0, 1'b1, "R9 still pending");
    // R5 clear with all data bits set, mask untouched
    step(1'b1, 1'b1, 4'd1, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R5 clear any data");
    idle(1, 1'b1, 1'b0, "R5 released");
    // polarity 0: falling edge counts
    @(negedge clk); pol = 1'b0;
    idle(4, 1'b1, 1'b0, "R3 pol change no event");
    step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R2 fall s1");
    idle(1, 1'b1, 1'b0, "R2 fall s2");
    idle(1, 1'b1, 1'b1, "R2 pending after fall");
    idle(1, 1'b0, 1'b1, "R5 mask kept after clear");
    // R10 unused address
    step(1'b0, 1'b1, 4'd2, 16'h0000, 1'b1, 1'b0, 1'b1, "R10 stray write");
    idle(1, 1'b0, 1'b1, "R10 mask unchanged");
    step(1'b0, 1'b1, 4'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 clear pol0");
    idle(1, 1'b1, 1'b0, "R7 release pol0");
    // R3 rise ignored with pol=0
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 4'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R3 rise ignored");
    @(negedge clk); in_word = 15'h5A3;
    idle(2, 1'b1, 1'b0, "R10 low bits pass");
    wr_en = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, expected done");
      end
    join_any
    #20;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule